// File: doc/BRIEF.md
# Remote DMA Byte-Count Engine

This block carries data between a host-side data port and a local packet store. Software first loads a 16-bit start address and a 16-bit byte count through 8-bit register writes and picks a transfer width. It then reads or writes the data port once per item. Every access touches the store at the current address. After the access the address moves forward by the width and the count falls by the same amount. When the count is used up, a completion flag is raised, and it stays up until software acknowledges it.

The address follows a ring. When an advance lands exactly on the ring limit, the address jumps back to the ring's first address. Only two windows of the address space hold real storage: a small block at the bottom, and a larger window higher up. Writes outside both windows are dropped, and reads outside them return all ones. Issuing a transfer command while the count is already zero raises completion at once. This gives software a cheap way to handle a zero-length transfer.

Top module: `rdma_engine`

## Requirements
- R1: A register write to select 0 or 1 loads the low or high byte of the current address. A write to select 2 or 3 loads the low or high byte of the remaining count. The other byte of the same field keeps its value.
- R2: The transfer width is set by bit 0 of the configuration register (select 4). With the bit set, every access advances the address by 2. With it clear, every access advances the address by 1.
- R3: When the remaining count is larger than the step, an access lowers the count by the step.
- R4: When the remaining count is at most the step, an access sets the count to 0 and raises `done`. This includes a count of 1 in 16-bit mode.
- R5: A data-port write while the count is 0 changes nothing: not the store, not the address, not the count.
- R6: In 16-bit mode, address bit 0 is ignored for the access. The byte at the even address is carried on data bits 7:0, and the byte at the next address is carried on bits 15:8.
- R7: Storage exists only at addresses below LOW_BYTES (32) and in the range [WIN_BASE, WIN_BASE+WIN_BYTES). A write elsewhere is dropped. A read elsewhere returns 16'hFFFF in 16-bit mode and 16'h00FF in 8-bit mode. The address and count still advance.
- R8: The ring first and ring limit addresses are page registers shifted left by 8: select 5 holds the first page, and select 6 holds the limit page. If an advanced address equals the ring limit address, the address becomes the ring first address instead.
- R9: A write to the control register (select 7) with bit 0 (read command) or bit 1 (write command) set raises `done` on the next cycle if the count is 0. If the count is not 0, such a write does not raise `done`.
- R10: A control write with bit 6 set clears `done`. If a set condition occurs in the same cycle, the set wins.
- R11: Read data is registered. `dp_rdata` and a one-cycle `dp_rvalid` pulse appear in the cycle after the `dp_rd` strobe.
- R12: An 8-bit read returns the byte at the exact current address on bits 7:0, with bits 15:8 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write byte |
| dp_rd | input | 1 | Data-port read strobe (wins over dp_wr) |
| dp_wr | input | 1 | Data-port write strobe |
| dp_wdata | input | 16 | Data-port write data |
| dp_rdata | output | 16 | Registered read data |
| dp_rvalid | output | 1 | Read data valid pulse |
| cur_addr | output | AW | Current address |
| remain | output | CW | Remaining byte count |
| done | output | 1 | Completion flag |

## Verification
Full byte-wide and word-wide sweeps fill and read back the store. They check the address and the count after every access. A wrong step, decrement or lane choice therefore shows up at once as a drifted address or a swapped byte. The corner cases get targeted checks:
- A count of 1 in 16-bit mode. A design that subtracts blindly would wrap the count to 65535 instead of finishing.
- A write at count 0. A leaky design would still advance the address or corrupt the store.
- An odd address in 16-bit mode. Without forcing to even, the access would read a misaligned word.
- The gap between the windows. An aliasing decoder would return stale data there instead of all ones.
- An advance onto the ring limit. A design that skips the wrap would step past the ring.
- Zero-length commands, and an acknowledge that collides with a set. A design that gets these wrong would leave software waiting forever or lose a completion.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [2:0] {
    SEL_ADDR_LO    = 3'd0,
    SEL_ADDR_HI    = 3'd1,
    SEL_CNT_LO     = 3'd2,
    SEL_CNT_HI     = 3'd3,
    SEL_CFG        = 3'd4,
    SEL_RING_FIRST = 3'd5,
    SEL_RING_LIMIT = 3'd6,
    SEL_CTRL       = 3'd7
  } rdma_sel_e;

  localparam int CFG_WIDE_BIT = 0;
  localparam int CTRL_RD_BIT  = 0;
  localparam int CTRL_WR_BIT  = 1;
  localparam int CTRL_ACK_BIT = 6;
endpackage

// File: rtl/rdma_cfg_regs.sv
module rdma_cfg_regs
  import rdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  output logic          wide,
  output logic [AW-1:0] ring_first,
  output logic [AW-1:0] ring_limit
);
  localparam int PW = AW - 8;

  logic [PW-1:0] first_pg_q, limit_pg_q;
  logic          wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q     <= 1'b0;
      first_pg_q <= '0;
      limit_pg_q <= '0;
    end else if (reg_wr) begin
      case (rdma_sel_e'(reg_sel))
        SEL_CFG:        wide_q     <= reg_wdata[CFG_WIDE_BIT];
        SEL_RING_FIRST: first_pg_q <= PW'(reg_wdata);
        SEL_RING_LIMIT: limit_pg_q <= PW'(reg_wdata);
        default: ;
      endcase
    end
  end

  assign wide       = wide_q;
  assign ring_first = {first_pg_q, 8'h00};
  assign ring_limit = {limit_pg_q, 8'h00};
endmodule

// File: rtl/rdma_walker.sv
module rdma_walker
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          access,
  input  logic          wide,
  input  logic [AW-1:0] ring_first,
  input  logic [AW-1:0] ring_limit,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] remain,
  output logic          done
);
  logic [AW-1:0] addr_q, step_a, bumped, wrapped;
  logic [CW-1:0] cnt_q, step_c;
  logic          done_q, last, is_ctrl, cmd_hit, set_done, ack;

  assign step_a  = wide ? AW'(2) : AW'(1);
  assign step_c  = wide ? CW'(2) : CW'(1);
  assign bumped  = addr_q + step_a;
  assign wrapped = (bumped == ring_limit) ? ring_first : bumped;
  assign last    = (cnt_q <= step_c);

  assign is_ctrl  = reg_wr && (rdma_sel_e'(reg_sel) == SEL_CTRL);
  assign cmd_hit  = is_ctrl && (reg_wdata[CTRL_RD_BIT] || reg_wdata[CTRL_WR_BIT]);
  assign ack      = is_ctrl && reg_wdata[CTRL_ACK_BIT];
  assign set_done = (access && last) || (cmd_hit && (cnt_q == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (access) begin
        addr_q <= wrapped;
        cnt_q  <= last ? '0 : (cnt_q - step_c);
      end
      if (reg_wr) begin
        case (rdma_sel_e'(reg_sel))
          SEL_ADDR_LO: addr_q[7:0]    <= reg_wdata;
          SEL_ADDR_HI: addr_q[AW-1:8] <= (AW-8)'(reg_wdata);
          SEL_CNT_LO:  cnt_q[7:0]     <= reg_wdata;
          SEL_CNT_HI:  cnt_q[CW-1:8]  <= (CW-8)'(reg_wdata);
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           done_q <= 1'b0;
    else if (set_done) done_q <= 1'b1;
    else if (ack)      done_q <= 1'b0;
  end

  assign addr   = addr_q;
  assign remain = cnt_q;
  assign done   = done_q;
endmodule

// File: rtl/rdma_win_map.sv
module rdma_win_map #(
  parameter int AW        = 16,
  parameter int LOW_BYTES = 32,
  parameter int WIN_BASE  = 16384,
  parameter int WIN_BYTES = 2048,
  parameter int IDX_W     = 11
) (
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam int LOW_WORDS = LOW_BYTES / 2;
  localparam int WIN_END   = WIN_BASE + WIN_BYTES;

  logic          in_low, in_win;
  logic [AW-1:0] off, word_pos;

  assign in_low   = addr < AW'(LOW_BYTES);
  assign in_win   = (addr >= AW'(WIN_BASE)) && (addr < AW'(WIN_END));
  assign off      = addr - AW'(WIN_BASE);
  assign word_pos = in_low ? (addr >> 1) : ((off >> 1) + AW'(LOW_WORDS));
  assign hit      = in_low || in_win;
  assign idx      = IDX_W'(word_pos);
endmodule

// File: rtl/rdma_word_ram.sv
module rdma_word_ram #(
  parameter int DEPTH = 1040,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       we,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata
);
  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we[0]) mem[idx][7:0]  <= wdata[7:0];
    if (we[1]) mem[idx][15:8] <= wdata[15:8];
    rdata <= mem[idx];
  end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine #(
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter int LOW_BYTES = 32,
  parameter int WIN_BASE  = 16384,
  parameter int WIN_BYTES = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          dp_rd,
  input  logic          dp_wr,
  input  logic [15:0]   dp_wdata,
  output logic [15:0]   dp_rdata,
  output logic          dp_rvalid,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] remain,
  output logic          done
);
  localparam int DEPTH = (LOW_BYTES + WIN_BYTES) / 2;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             cfg_wide;
  logic [AW-1:0]    ring_first, ring_limit, acc_addr;
  logic             access, wr_go, hit;
  logic [IDX_W-1:0] idx;
  logic [1:0]       lane_we;
  logic [15:0]      ram_wdata, ram_q;
  logic             rvalid_q, miss_q, wide_q, lane_q;

  rdma_cfg_regs #(.AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .wide(cfg_wide),
    .ring_first(ring_first), .ring_limit(ring_limit)
  );

  assign wr_go  = dp_wr && !dp_rd && (remain != '0);
  assign access = dp_rd || wr_go;

  rdma_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .access(access), .wide(cfg_wide),
    .ring_first(ring_first), .ring_limit(ring_limit),
    .addr(cur_addr), .remain(remain), .done(done)
  );

  assign acc_addr = cfg_wide ? {cur_addr[AW-1:1], 1'b0} : cur_addr;

  rdma_win_map #(
    .AW(AW), .LOW_BYTES(LOW_BYTES), .WIN_BASE(WIN_BASE),
    .WIN_BYTES(WIN_BYTES), .IDX_W(IDX_W)
  ) u_map (
    .addr(acc_addr), .hit(hit), .idx(idx)
  );

  always_comb begin
    lane_we = 2'b00;
    if (wr_go && hit) begin
      if (cfg_wide)         lane_we = 2'b11;
      else if (acc_addr[0]) lane_we = 2'b10;
      else                  lane_we = 2'b01;
    end
  end

  assign ram_wdata = cfg_wide ? dp_wdata : {dp_wdata[7:0], dp_wdata[7:0]};

  rdma_word_ram #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .idx(idx), .we(lane_we), .wdata(ram_wdata), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      miss_q   <= 1'b0;
      wide_q   <= 1'b0;
      lane_q   <= 1'b0;
    end else begin
      rvalid_q <= dp_rd;
      if (dp_rd) begin
        miss_q <= !hit;
        wide_q <= cfg_wide;
        lane_q <= acc_addr[0];
      end
    end
  end

  always_comb begin
    if (miss_q)      dp_rdata = wide_q ? 16'hFFFF : 16'h00FF;
    else if (wide_q) dp_rdata = ram_q;
    else             dp_rdata = {8'h00, lane_q ? ram_q[15:8] : ram_q[7:0]};
  end

  assign dp_rvalid = rvalid_q;
endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [2:0]    reg_sel,
  input logic [7:0]    reg_wdata,
  input logic          dp_rd,
  input logic          dp_wr,
  input logic          dp_rvalid,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] remain,
  input logic          done,
  input logic          cfg_wide
);
  logic          acc;
  logic [CW-1:0] stp;
  assign acc = dp_rd || (dp_wr && remain != '0);
  assign stp = cfg_wide ? CW'(2) : CW'(1);

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (rst)
    dp_rd |=> dp_rvalid);
  assert_no_rvalid_R11: assert property (@(posedge clk) disable iff (rst)
    !dp_rd |=> !dp_rvalid);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && !reg_wr && remain > stp) |=> (remain == $past(remain) - $past(stp)));
  assert_finish_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && !reg_wr && remain <= stp) |=> (done && remain == '0));
  assert_idle_write_R5: assert property (@(posedge clk) disable iff (rst)
    (dp_wr && !dp_rd && !reg_wr && remain == '0) |=> ($stable(cur_addr) && remain == '0));
  assert_zero_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 3'd7 && (reg_wdata[0] || reg_wdata[1]) && remain == '0) |=> done);
  assert_ack_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 3'd7 && reg_wdata[6] && reg_wdata[1:0] == 2'b00 && !dp_rd && !dp_wr)
      |=> !done);
endmodule

bind rdma_engine rdma_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .dp_rd(dp_rd), .dp_wr(dp_wr),
  .dp_rvalid(dp_rvalid), .cur_addr(cur_addr), .remain(remain),
  .done(done), .cfg_wide(cfg_wide)
);

// File: tb/tb_rdma_engine.sv
module tb_rdma_engine;
  localparam int WINB  = 512;
  localparam int WBASE = 16384;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        dp_rd = 1'b0, dp_wr = 1'b0;
  logic [15:0] dp_wdata = '0;
  logic [15:0] dp_rdata;
  logic        dp_rvalid;
  logic [15:0] cur_addr, remain;
  logic        done;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] lo_m [32];
  logic [7:0] win_m [WINB];

  always #2 clk = ~clk;

  rdma_engine #(.WIN_BYTES(WINB)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dp_rd(dp_rd), .dp_wr(dp_wr),
    .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .dp_rvalid(dp_rvalid),
    .cur_addr(cur_addr), .remain(remain), .done(done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit valid(input int a);
    return (a < 32) || (a >= WBASE && a < WBASE + WINB);
  endfunction

  function automatic logic [7:0] mget(input int a);
    if (a < 32) return lo_m[a];
    return win_m[a - WBASE];
  endfunction

  task automatic mput(input int a, input logic [7:0] v);
    if (a < 32) lo_m[a] = v;
    else if (a >= WBASE && a < WBASE + WINB) win_m[a - WBASE] = v;
  endtask

  task automatic reg_w(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_addr(input logic [15:0] a);
    reg_w(3'd0, a[7:0]); reg_w(3'd1, a[15:8]);
  endtask

  task automatic set_cnt(input logic [15:0] c);
    reg_w(3'd2, c[7:0]); reg_w(3'd3, c[15:8]);
  endtask

  task automatic dpw(input logic [15:0] d);
    @(negedge clk);
    dp_wr = 1'b1; dp_wdata = d;
    @(negedge clk);
    dp_wr = 1'b0;
  endtask

  task automatic dpr(output logic [15:0] d, output logic v);
    @(negedge clk);
    dp_rd = 1'b1;
    @(negedge clk);
    dp_rd = 1'b0;
    d = dp_rdata; v = dp_rvalid;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic        rv;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("reset addr", cur_addr, 0);
    check("reset remain", remain, 0);
    check("reset done", done, 0);
    check("reset rvalid", dp_rvalid, 0);

    // R1 byte-half loads
    set_addr(16'h1234);
    check("R1 addr load", cur_addr, 16'h1234);
    reg_w(3'd0, 8'h78);
    check("R1 addr low keeps high", cur_addr, 16'h1278);
    set_cnt(16'hABCD);
    reg_w(3'd3, 8'h01);
    check("R1 count high keeps low", remain, 16'h01CD);

    reg_w(3'd5, 8'h40);
    reg_w(3'd6, 8'h80);

    // R2 R3 R4: byte-mode fill of low block
    reg_w(3'd4, 8'h00);
    set_addr(16'h0000);
    set_cnt(16'd32);
    for (int i = 0; i < 32; i++) begin
      b = 8'((i * 7 + 3) & 8'hFF);
      dpw({8'h5A, b});
      mput(i, b);
      check("R2 byte step addr", cur_addr, i + 1);
      check("R3 count step", remain, 31 - i);
      check("R4 done timing", done, (i == 31) ? 1 : 0);
    end
    reg_w(3'd7, 8'h40);
    check("R10 ack clears", done, 0);

    // R12 R11: byte read-back
    set_addr(16'h0000);
    set_cnt(16'd32);
    for (int i = 0; i < 32; i++) begin
      dpr(rd, rv);
      check("R11 rvalid", rv, 1);
      check("R12 byte read", rd, {8'h00, mget(i)});
    end
    reg_w(3'd7, 8'h40);

    // R5: write at zero count
    set_addr(16'h0005);
    check("R5 precondition", remain, 0);
    dpw(16'h00EE);
    check("R5 addr held", cur_addr, 16'h0005);
    check("R5 count held", remain, 0);
    set_cnt(16'd1);
    dpr(rd, rv);
    check("R5 store untouched", rd, {8'h00, mget(5)});
    reg_w(3'd7, 8'h40);

    // R6: word-mode fill of window, little-endian
    reg_w(3'd4, 8'h01);
    set_addr(16'h4000);
    set_cnt(16'd64);
    for (int i = 0; i < 32; i++) begin
      logic [15:0] w;
      w = {8'(i + 8'h80), 8'(i * 3)};
      dpw(w);
      mput(WBASE + 2 * i, w[7:0]);
      mput(WBASE + 2 * i + 1, w[15:8]);
      check("R2 word step addr", cur_addr, 16'h4000 + 2 * (i + 1));
      check("R3 word count", remain, 62 - 2 * i);
    end
    reg_w(3'd7, 8'h40);
    reg_w(3'd4, 8'h00);
    set_addr(16'h4000);
    set_cnt(16'd16);
    for (int i = 0; i < 16; i++) begin
      dpr(rd, rv);
      check("R6 byte order", rd, {8'h00, mget(WBASE + i)});
    end
    reg_w(3'd4, 8'h01);
    set_addr(16'h4003);
    set_cnt(16'd2);
    dpr(rd, rv);
    check("R6 odd forced even", rd, {mget(WBASE + 3), mget(WBASE + 2)});
    check("R6 odd addr advance", cur_addr, 16'h4005);
    reg_w(3'd7, 8'h40);

    // R4 edge: count 1 in word mode
    set_addr(16'h4010);
    set_cnt(16'd3);
    dpw(16'hC0DE);
    mput(WBASE + 16, 8'hDE); mput(WBASE + 17, 8'hC0);
    check("R3 3 minus 2", remain, 1);
    check("R4 not yet done", done, 0);
    dpw(16'hBEEF);
    mput(WBASE + 18, 8'hEF); mput(WBASE + 19, 8'hBE);
    check("R4 count 1 word", remain, 0);
    check("R4 done set", done, 1);
    dpw(16'h1111);
    check("R5 extra write addr", cur_addr, 16'h4014);
    reg_w(3'd7, 8'h40);
    set_addr(16'h4014);
    set_cnt(16'd2);
    dpr(rd, rv);
    check("R5 extra write dropped", rd, {mget(WBASE + 21), mget(WBASE + 20)});
    reg_w(3'd7, 8'h40);

    // R7: outside the windows
    set_addr(16'h0100);
    set_cnt(16'd4);
    dpw(16'h1234);
    check("R7 gap addr advance", cur_addr, 16'h0102);
    set_addr(16'h0100);
    dpr(rd, rv);
    check("R7 gap word read", rd, 16'hFFFF);
    reg_w(3'd4, 8'h00);
    set_addr(16'h4200);
    set_cnt(16'd2);
    dpr(rd, rv);
    check("R7 above window byte", rd, 16'h00FF);
    set_addr(16'h0020);
    dpw(16'h0077);
    set_addr(16'h0020);
    set_cnt(16'd1);
    dpr(rd, rv);
    check("R7 first gap byte", rd, 16'h00FF);
    set_addr(16'h0000);
    set_cnt(16'd1);
    dpr(rd, rv);
    check("R7 no alias low", rd, {8'h00, mget(0)});
    set_addr(16'h4000);
    set_cnt(16'd1);
    dpr(rd, rv);
    check("R7 no alias window", rd, {8'h00, mget(WBASE)});
    reg_w(3'd7, 8'h40);

    // R8: ring wrap
    reg_w(3'd6, 8'h41);
    reg_w(3'd4, 8'h01);
    set_addr(16'h40FE);
    set_cnt(16'd4);
    dpw(16'h2468);
    check("R8 word wrap", cur_addr, 16'h4000);
    reg_w(3'd4, 8'h00);
    set_addr(16'h40FF);
    dpr(rd, rv);
    check("R8 byte wrap", cur_addr, 16'h4000);
    reg_w(3'd6, 8'h80);
    reg_w(3'd7, 8'h40);

    // R9 R10: commands
    set_cnt(16'd0);
    reg_w(3'd7, 8'h01);
    check("R9 zero read cmd", done, 1);
    reg_w(3'd7, 8'h40);
    check("R10 clear", done, 0);
    reg_w(3'd7, 8'h02);
    check("R9 zero write cmd", done, 1);
    reg_w(3'd7, 8'h40);
    set_cnt(16'd5);
    reg_w(3'd7, 8'h02);
    check("R9 nonzero cmd", done, 0);
    set_cnt(16'd0);
    reg_w(3'd7, 8'h42);
    check("R10 set beats clear", done, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule